// File: doc/BRIEF.md
# Event Timestamp Capture Unit

The block keeps a local nanosecond-scale time counter and stamps external events against it. Each clock the counter advances by a programmable increment. Periodically a reference time value arrives with a strobe, taken from a network-disciplined clock. The counter is then pulled onto that reference. A large error is fixed in one jump. A small error is worked off gradually, so timestamps taken from the counter share one timeline with the network time.

Several asynchronous event pins feed one capture channel each. Typical sources are an encoder index, a limit or home switch, or a protection comparator. Every pin is synchronised and edge-detected. An armed rising or falling edge latches the counter into that channel's register. A shared latch pin latches the counter into every channel on the same cycle. Software reads a channel through a select-and-read port, and the read frees the channel. A capture that finds its channel still unread is dropped, and a sticky overflow flag is raised.

Top module: `evt_stamp_unit`

## Requirements
- R1: While reset is held low, cur_time is zero and every valid and overflow flag is zero.
- R2: In any cycle with no strobe and no pending slew, cur_time grows by exactly inc_ns on each rising clock edge.
- R3: A strobe whose offset (ref_time minus cur_time, signed) is larger in magnitude than STEP_LIM makes cur_time equal ref_time + inc_ns after that edge and cancels any pending slew.
- R4: A strobe whose offset magnitude is at most STEP_LIM advances the counter by inc_ns on that edge and sets the pending slew to the offset. The new value replaces any earlier pending slew. Each later edge adds inc_ns+1 while the pending slew is positive, or inc_ns-1 while it is negative, and moves the slew one unit toward zero. Outside step loads the counter never decreases.
- R5: A rising edge on evt_pin[i] is captured only when arm_rise[i] is 1, and a falling edge only when arm_fall[i] is 1. Disarmed edges leave the channel untouched.
- R6: Suppose a pin change is first sampled at clock edge k. The captured value is then the cur_time shown between edges k+1 and k+2, and the valid flag is set after edge k+2.
- R7: A rising edge on latch_pin, with the same two-stage latency, captures into every channel regardless of arm bits. All channels that were free receive the identical value.
- R8: A capture on a channel whose valid flag is already set keeps the stored stamp and sets that channel's overflow flag, which stays set until the channel is read.
- R9: rd_stamp, rd_valid and rd_ovf show the channel chosen by rd_sel in the same cycle. A cycle with rd_en high clears the valid and overflow flags of that channel.
- R10: When a read and a capture hit the same channel on the same edge, the new value is stored, valid stays 1 and overflow is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_ns | input | INCW | Counter increment per clock (at least 1) |
| ref_time | input | TW | Reference time sampled on a strobe |
| ref_strobe | input | 1 | Apply a correction against ref_time |
| evt_pin | input | NCH | Asynchronous event inputs, one per channel |
| latch_pin | input | 1 | Asynchronous shared latch input |
| arm_rise | input | NCH | Per-channel rising-edge arm |
| arm_fall | input | NCH | Per-channel falling-edge arm |
| rd_en | input | 1 | Read strobe, frees the selected channel |
| rd_sel | input | SW | Channel select for the read port |
| cur_time | output | TW | Local time counter |
| rd_stamp | output | TW | Stamp of the selected channel |
| rd_valid | output | 1 | Valid flag of the selected channel |
| rd_ovf | output | 1 | Overflow flag of the selected channel |
| valid_vec | output | NCH | Valid flags of all channels |
| ovf_vec | output | NCH | Overflow flags of all channels |

## Verification
The counter is driven four ways: free running, a large forward jump, a small forward slew and a small backward slew. Together these separate the step path from the slew path and check the inc_ns±1 rate and the monotonic property. A final run compares against a drifting reference with periodic strobes. Event pins get armed and disarmed edges of both polarities, to separate polarity selection from plain edge detection. Repeated edges without a read expose overflow handling. A read placed exactly on a capture edge tests the read-versus-capture priority. A shared latch pulse with all channels free shows whether every channel takes one common value.

// File: rtl/evt_stamp_unit.sv
module evt_stamp_unit #(
  parameter int NCH = 4,
  parameter int TW = 64,
  parameter int INCW = 8,
  parameter int STEP_LIM = 64,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [INCW-1:0] inc_ns,
  input  logic [TW-1:0]   ref_time,
  input  logic            ref_strobe,
  input  logic [NCH-1:0]  evt_pin,
  input  logic            latch_pin,
  input  logic [NCH-1:0]  arm_rise,
  input  logic [NCH-1:0]  arm_fall,
  input  logic            rd_en,
  input  logic [SW-1:0]   rd_sel,
  output logic [TW-1:0]   cur_time,
  output logic [TW-1:0]   rd_stamp,
  output logic            rd_valid,
  output logic            rd_ovf,
  output logic [NCH-1:0]  valid_vec,
  output logic [NCH-1:0]  ovf_vec
);

  localparam logic signed [TW-1:0] LIM = TW'(STEP_LIM);
  localparam logic signed [TW-1:0] ONE = 1;

  logic [TW-1:0] tcnt;
  logic signed [TW-1:0] slew;
  logic [TW-1:0] incx;
  logic signed [TW-1:0] off;
  logic big;

  assign incx = {{(TW-INCW){1'b0}}, inc_ns};
  assign off  = $signed(ref_time - tcnt);
  assign big  = (off > LIM) || (off < -LIM);
  assign cur_time = tcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
      slew <= '0;
    end else if (ref_strobe) begin
      if (big) begin
        tcnt <= ref_time + incx;
        slew <= '0;
      end else begin
        tcnt <= tcnt + incx;
        slew <= off;
      end
    end else if (slew > 0) begin
      tcnt <= tcnt + incx + ONE;
      slew <= slew - ONE;
    end else if (slew < 0) begin
      tcnt <= tcnt + incx - ONE;
      slew <= slew + ONE;
    end else begin
      tcnt <= tcnt + incx;
    end
  end

  logic [NCH:0] s1, s2, s3;
  logic [NCH:0] rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= {latch_pin, evt_pin};
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  logic [NCH*TW-1:0] stamp_flat;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [TW-1:0] st;
    logic v, o;
    logic hit, rdh;

    assign hit = (rise[i] & arm_rise[i]) | (fall[i] & arm_fall[i]) | rise[NCH];
    assign rdh = rd_en && (rd_sel == SW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st <= '0;
        v  <= 1'b0;
        o  <= 1'b0;
      end else if (hit) begin
        if (v && !rdh) begin
          o <= 1'b1;
        end else begin
          st <= tcnt;
          v  <= 1'b1;
          o  <= 1'b0;
        end
      end else if (rdh) begin
        v <= 1'b0;
        o <= 1'b0;
      end
    end

    assign stamp_flat[i*TW +: TW] = st;
    assign valid_vec[i] = v;
    assign ovf_vec[i] = o;

    // R8
    ovf_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_vec[i] |-> valid_vec[i]);

    // R8
    stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_vec[i] && !(rd_en && rd_sel == SW'(i))) |=> $stable(stamp_flat[i*TW +: TW]));

    if (i > 0) begin : g_sim
      // R7
      latch_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(valid_vec[i]) && $rose(valid_vec[0])) |-> stamp_flat[i*TW +: TW] == stamp_flat[0 +: TW]);
    end
  end

  assign rd_stamp = stamp_flat[rd_sel*TW +: TW];
  assign rd_valid = valid_vec[rd_sel];
  assign rd_ovf   = ovf_vec[rd_sel];

  // R4
  time_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_strobe |=> cur_time >= $past(cur_time));

  // R4
  time_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_strobe |=> (cur_time - $past(cur_time)) <= ($past(incx) + ONE));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (cur_time == '0 || rst_n) && (valid_vec == '0 || rst_n));

endmodule

// File: tb/sim_evt_stamp_unit.sv
`timescale 1ns/1ps
module sim_evt_stamp_unit;
  localparam int NCH = 4;
  localparam int TW = 64;
  localparam int STEP_LIM = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] inc_ns = 8'd10;
  logic [TW-1:0] ref_time = '0;
  logic ref_strobe = 1'b0;
  logic [NCH-1:0] evt_pin = '0;
  logic latch_pin = 1'b0;
  logic [NCH-1:0] arm_rise = '0;
  logic [NCH-1:0] arm_fall = '0;
  logic rd_en = 1'b0;
  logic [1:0] rd_sel = '0;
  logic [TW-1:0] cur_time, rd_stamp;
  logic rd_valid, rd_ovf;
  logic [NCH-1:0] valid_vec, ovf_vec;

  always #2.5 clk = ~clk;

  evt_stamp_unit #(.NCH(NCH), .TW(TW), .INCW(8), .STEP_LIM(STEP_LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .inc_ns(inc_ns), .ref_time(ref_time),
    .ref_strobe(ref_strobe), .evt_pin(evt_pin), .latch_pin(latch_pin),
    .arm_rise(arm_rise), .arm_fall(arm_fall), .rd_en(rd_en), .rd_sel(rd_sel),
    .cur_time(cur_time), .rd_stamp(rd_stamp), .rd_valid(rd_valid), .rd_ovf(rd_ovf),
    .valid_vec(valid_vec), .ovf_vec(ovf_vec));

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [63:0] mt;
  longint mrem;
  logic [63:0] mst [NCH];
  bit mv [NCH];
  bit mo [NCH];
  logic [NCH:0] d1, d2, d3;

  always @(posedge clk) begin
    if (!rst_n) begin
      mt = 0; mrem = 0; d1 = 0; d2 = 0; d3 = 0;
      for (int i = 0; i < NCH; i++) begin mst[i] = 0; mv[i] = 0; mo[i] = 0; end
    end else begin
      bit lat;
      lat = d2[NCH] && !d3[NCH];
      for (int i = 0; i < NCH; i++) begin
        bit h, rsel;
        h = (d2[i] && !d3[i] && arm_rise[i]) || (!d2[i] && d3[i] && arm_fall[i]) || lat;
        rsel = rd_en && (int'(rd_sel) == i);
        if (h) begin
          if (mv[i] && !rsel) mo[i] = 1;
          else begin mst[i] = mt; mv[i] = 1; mo[i] = 0; end
        end else if (rsel) begin
          mv[i] = 0; mo[i] = 0;
        end
      end
      d3 = d2; d2 = d1; d1 = {latch_pin, evt_pin};
      if (ref_strobe) begin
        longint o;
        o = longint'(ref_time - mt);
        if (o > STEP_LIM || o < -STEP_LIM) begin mt = ref_time + 64'(inc_ns); mrem = 0; end
        else begin mt = mt + 64'(inc_ns); mrem = o; end
      end else if (mrem > 0) begin mt = mt + 64'(inc_ns) + 1; mrem--; end
      else if (mrem < 0) begin mt = mt + 64'(inc_ns) - 1; mrem++; end
      else mt = mt + 64'(inc_ns);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_time == mt, "R2/R3/R4", "cur_time", cur_time, mt);
      for (int i = 0; i < NCH; i++) begin
        chk(valid_vec[i] == mv[i], "R5/R6", "valid", 64'(valid_vec[i]), 64'(mv[i]));
        chk(ovf_vec[i] == mo[i], "R8", "ovf", 64'(ovf_vec[i]), 64'(mo[i]));
      end
      chk(rd_stamp == mst[rd_sel], "R9", "rd_stamp", rd_stamp, mst[rd_sel]);
      chk(rd_valid == mv[rd_sel], "R9", "rd_valid", 64'(rd_valid), 64'(mv[rd_sel]));
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog (all R) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] x, e;
    logic [63:0] refc;
    repeat (3) cyc();
    // R1 reset state
    chk(cur_time == 0, "R1", "reset cur_time", cur_time, 0);
    chk(valid_vec == 0 && ovf_vec == 0, "R1", "reset flags", {valid_vec, ovf_vec}, 0);
    rst_n = 1'b1;
    cyc(); x = cur_time; cyc();
    // R2 free run
    chk(cur_time - x == 10, "R2", "free-run delta", cur_time - x, 10);

    // R3 step forward
    x = cur_time;
    ref_time = x + 1000; ref_strobe = 1; cyc(); ref_strobe = 0;
    chk(cur_time == x + 1010, "R3", "step load", cur_time, x + 1010);

    // R4 positive slew of 20
    x = cur_time;
    ref_time = x + 20; ref_strobe = 1; cyc(); ref_strobe = 0;
    repeat (21) cyc();
    chk(cur_time == x + 22*10 + 20, "R4", "positive slew", cur_time, x + 240);
    x = cur_time; cyc();
    chk(cur_time - x == 10, "R4", "slew finished", cur_time - x, 10);

    // R4 negative slew of 15
    x = cur_time;
    ref_time = x - 15; ref_strobe = 1; cyc(); ref_strobe = 0;
    x = cur_time; cyc();
    chk(cur_time - x == 9, "R4", "negative slew rate", cur_time - x, 9);
    repeat (20) cyc();

    // R5 R6 armed rising edge on channel 0
    arm_rise = 4'b0001; arm_fall = 4'b0100;
    evt_pin[0] = 1; cyc();
    cyc(); e = cur_time; cyc();
    rd_sel = 0;
    chk(rd_valid == 1 && rd_stamp == e, "R6", "rise capture stamp", rd_stamp, e);

    // R5 disarmed falling edge on channel 1 and disarmed rising on channel 3
    evt_pin[1] = 1; cyc(); evt_pin[1] = 0; evt_pin[3] = 1; repeat (5) cyc();
    chk(valid_vec[1] == 0 && valid_vec[3] == 0, "R5", "disarmed edges ignored", 64'(valid_vec), 1);

    // R8 second edge on channel 0 before read
    evt_pin[0] = 0; arm_fall[0] = 1; repeat (5) cyc();
    chk(rd_stamp == e && rd_ovf == 1, "R8", "overflow keeps old", rd_stamp, e);

    // R9 read clears channel 0
    rd_en = 1; cyc(); rd_en = 0;
    chk(valid_vec[0] == 0 && ovf_vec[0] == 0, "R9", "read clears", {valid_vec, ovf_vec}, 0);

    // R10 read and capture on same edge, channel 2 falling armed
    evt_pin[2] = 1; arm_rise[2] = 1; repeat (4) cyc();
    evt_pin[2] = 0; cyc();
    cyc(); e = cur_time; rd_en = 1; rd_sel = 2; cyc(); rd_en = 0;
    chk(rd_valid == 1 && rd_ovf == 0 && rd_stamp == e, "R10", "read+capture", rd_stamp, e);

    // R7 shared latch, all channels free
    for (int i = 0; i < NCH; i++) begin rd_sel = 2'(i); rd_en = 1; cyc(); end
    rd_en = 0; rd_sel = 0;
    latch_pin = 1; cyc(); cyc(); e = cur_time; cyc(); latch_pin = 0;
    for (int i = 0; i < NCH; i++) begin
      rd_sel = 2'(i); #0.5;
      chk(rd_valid == 1 && rd_stamp == e, "R7", "latch simultaneity", rd_stamp, e);
    end

    // drifting reference with random events and reads
    arm_rise = 4'b1011; arm_fall = 4'b0110;
    refc = cur_time;
    for (int c = 0; c < 3000; c++) begin
      refc = refc + 10 + ((c % 7 == 0) ? 1 : 0) + ((c % 400 == 399) ? 200 : 0);
      ref_strobe = (c % 40 == 39);
      ref_time = refc + 10;
      if ($urandom % 6 == 0) evt_pin[$urandom % NCH] ^= 1'b1;
      latch_pin = ($urandom % 97 == 0);
      rd_en = ($urandom % 5 == 0);
      rd_sel = 2'($urandom % NCH);
      cyc();
    end
    ref_strobe = 0; rd_en = 0;
    repeat (5) cyc();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule